// File: doc/BRIEF.md
# Sensor Threshold Alarm Comparator

This block watches a stream of finished sensor readings and raises one alarm line per monitored quantity. Channel 0 is the die temperature. Channels 1 to 6 are supply rails. Each reading arrives as a 12-bit code together with a channel index and a one-cycle strobe. The block compares that code with the limits stored for its channel. The limits live in a 16-slot bank of 16-bit words that software writes through a simple write port. Only the top 12 bits of each word take part in a comparison.

The supply rails use a stateless window test. The alarm follows the latest reading: it is high when that reading lies outside the limits and low when it lies inside. The temperature channel uses hysteresis instead. Its alarm latches on when a reading exceeds the high limit. It only drops when a reading falls below the low limit. A separate configuration word carries one disable bit per alarm. A set bit masks the output, while the channel's internal state keeps tracking new readings.

Top module: `sensor_alarm`

## Requirements
- R1: For a supply channel (index 1 to 6), a reading whose code is strictly greater than bits [15:4] of its high-limit slot, or strictly less than bits [15:4] of its low-limit slot, makes that channel's alarm bit high.
- R2: For a supply channel, a reading equal to either limit or between them makes that alarm bit low, whatever its previous value.
- R3: The temperature alarm (bit 0) goes high on a reading above its high limit. It holds its value on readings inside the inclusive window. It goes low only on a reading strictly below its low limit.
- R4: Bank slots: 0, 1 and 2 hold the high limits of channels 0, 1 and 2. Slots 4, 5 and 6 hold their low limits. Slots 8 to 11 hold the high limits of channels 3 to 6, and slots 12 to 15 hold their low limits. Slots 3 and 7 are stored but affect no alarm. Bits [3:0] of every slot are ignored.
- R5: Alarm output bit c is the channel's alarm state ANDed with the inverse of disable bit c. The disable mask is written through the configuration port and takes effect on the following clock. A channel's state keeps updating while it is masked.
- R6: An alarm bit changes only on the rising edge that samples a strobe for its own channel, or on a configuration write. A strobe for one channel leaves every other alarm bit unchanged.
- R7: An active-low asynchronous reset clears all alarm states and the disable mask. It loads every high-limit slot (0 to 3 and 8 to 11) with 16'hFFF0 and every low-limit slot (4 to 7 and 12 to 15) with 16'h0000.
- R8: A strobe carrying channel index 7 changes no alarm bit.
- R9: Writing a limit does not re-evaluate any alarm. A reading strobed in the same cycle as a limit write is compared with the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| thrWrEn | input | 1 | Limit bank write strobe |
| thrWrAddr | input | 4 | Limit bank slot to write |
| thrWrData | input | 16 | Limit word, compared bits in [15:4] |
| cfgWrEn | input | 1 | Disable-mask write strobe |
| cfgWrData | input | 7 | Disable mask, bit c masks alarm c |
| measValid | input | 1 | Reading strobe |
| measChan | input | 3 | Channel index of the reading |
| measCode | input | 12 | Final 12-bit reading code |
| alarm | output | 7 | Alarm lines, bit c for channel c |

## Verification
The assertions rely on a few assumptions about the inputs. Reset is assumed to be released away from a rising edge. A strobe is assumed to name a single channel, or index 7. They also assume that alarm bits move only through a reading for that channel or through a configuration write, so they check stability whenever neither of those happens. The stimulus drives every input on the falling edge and holds it for a full cycle. It deliberately includes index 7, limit writes that coincide with readings, and configuration writes that coincide with readings, so the assertion guards are actually exercised.

// File: rtl/sensor_alarm_pkg.sv
`timescale 1ns/1ps
package sensor_alarm_pkg;
  localparam int CODE_W     = 12;
  localparam int THR_W      = 16;
  localparam int NUM_CH     = 7;
  localparam int BANK_DEPTH = 16;
  localparam int ADDR_W     = $clog2(BANK_DEPTH);
  localparam int CHAN_W     = $clog2(NUM_CH + 1);
  localparam int TEMP_CH    = 0;
  localparam int HALF_BANK  = BANK_DEPTH / 2;
  localparam logic [THR_W-1:0] HIGH_RST = {{CODE_W{1'b1}}, {(THR_W-CODE_W){1'b0}}};
  localparam logic [THR_W-1:0] LOW_RST  = '0;

  typedef struct packed {
    logic [NUM_CH-1:0]     evalSel;
    logic [BANK_DEPTH-1:0] bankWe;
    logic                  cfgWe;
  } alarmStrobes_t;

  // slot holding the high limit of a channel
  function automatic logic [ADDR_W-1:0] highSlot(input logic [CHAN_W-1:0] ch);
    logic [ADDR_W-1:0] s;
    case (ch)
      3'd0, 3'd1, 3'd2: s = ADDR_W'(ch);
      3'd3, 3'd4, 3'd5, 3'd6: s = ADDR_W'(ch) + ADDR_W'(5);
      default: s = '0;
    endcase
    return s;
  endfunction

  // slot holding the low limit of a channel
  function automatic logic [ADDR_W-1:0] lowSlot(input logic [CHAN_W-1:0] ch);
    logic [ADDR_W-1:0] s;
    case (ch)
      3'd0, 3'd1, 3'd2: s = ADDR_W'(ch) + ADDR_W'(4);
      3'd3, 3'd4, 3'd5, 3'd6: s = ADDR_W'(ch) + ADDR_W'(9);
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sensor_alarm_ctrl.sv
`timescale 1ns/1ps
module sensor_alarm_ctrl
  import sensor_alarm_pkg::*;
(
  input  logic              thrWrEn,
  input  logic [ADDR_W-1:0] thrWrAddr,
  input  logic              cfgWrEn,
  input  logic              measValid,
  input  logic [CHAN_W-1:0] measChan,
  output alarmStrobes_t     strb
);
  genvar gc, gs;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_eval
      assign strb.evalSel[gc] = measValid && (measChan == CHAN_W'(gc));
    end
    for (gs = 0; gs < BANK_DEPTH; gs++) begin : g_we
      assign strb.bankWe[gs] = thrWrEn && (thrWrAddr == ADDR_W'(gs));
    end
  endgenerate
  assign strb.cfgWe = cfgWrEn;
endmodule

// File: rtl/sensor_alarm_dp.sv
`timescale 1ns/1ps
module sensor_alarm_dp
  import sensor_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  alarmStrobes_t     strb,
  input  logic [THR_W-1:0]  thrWrData,
  input  logic [NUM_CH-1:0] cfgWrData,
  input  logic [CHAN_W-1:0] measChan,
  input  logic [CODE_W-1:0] measCode,
  output logic [NUM_CH-1:0] alarm
);
  logic [THR_W-1:0]  bank [BANK_DEPTH];
  logic [NUM_CH-1:0] alarmState;
  logic [NUM_CH-1:0] disMask;
  logic [CODE_W-1:0] highLim;
  logic [CODE_W-1:0] lowLim;
  logic              aboveHigh;
  logic              belowLow;

  genvar gs, gc;
  generate
    for (gs = 0; gs < BANK_DEPTH; gs++) begin : g_bank
      localparam logic [THR_W-1:0] RST_VAL =
        ((gs % HALF_BANK) >= (HALF_BANK / 2)) ? LOW_RST : HIGH_RST;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               bank[gs] <= RST_VAL;
        else if (strb.bankWe[gs]) bank[gs] <= thrWrData;
      end
    end
  endgenerate

  // shared limit selection and one comparator pair
  always_comb begin
    highLim   = bank[highSlot(measChan)][THR_W-1 -: CODE_W];
    lowLim    = bank[lowSlot(measChan)][THR_W-1 -: CODE_W];
    aboveHigh = measCode > highLim;
    belowLow  = measCode < lowLim;
  end

  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_state
      if (gc == TEMP_CH) begin : g_hyst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) alarmState[gc] <= 1'b0;
          else if (strb.evalSel[gc]) begin
            if (aboveHigh)     alarmState[gc] <= 1'b1;
            else if (belowLow) alarmState[gc] <= 1'b0;
          end
        end
      end else begin : g_window
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                  alarmState[gc] <= 1'b0;
          else if (strb.evalSel[gc])  alarmState[gc] <= aboveHigh || belowLow;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          disMask <= '0;
    else if (strb.cfgWe) disMask <= cfgWrData;
  end

  assign alarm = alarmState & ~disMask;
endmodule

// File: rtl/sensor_alarm.sv
`timescale 1ns/1ps
module sensor_alarm
  import sensor_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        thrWrEn,
  input  logic [3:0]  thrWrAddr,
  input  logic [15:0] thrWrData,
  input  logic        cfgWrEn,
  input  logic [6:0]  cfgWrData,
  input  logic        measValid,
  input  logic [2:0]  measChan,
  input  logic [11:0] measCode,
  output logic [6:0]  alarm
);
  alarmStrobes_t strb;

  sensor_alarm_ctrl u_ctrl (
    .thrWrEn   (thrWrEn),
    .thrWrAddr (thrWrAddr),
    .cfgWrEn   (cfgWrEn),
    .measValid (measValid),
    .measChan  (measChan),
    .strb      (strb)
  );

  sensor_alarm_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .thrWrData (thrWrData),
    .cfgWrData (cfgWrData),
    .measChan  (measChan),
    .measCode  (measCode),
    .alarm     (alarm)
  );
endmodule

// File: rtl/sensor_alarm_chk.sv
`timescale 1ns/1ps
module sensor_alarm_chk
  import sensor_alarm_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [6:0]  cfgWrData,
  input logic        measValid,
  input logic [2:0]  measChan,
  input logic [6:0]  alarm
);
  // R7: outputs cleared while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r7_reset_clear: assert (alarm == '0);
    end
  end

  // R8: index 7 touches nothing
  a_r8_bad_chan_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (measValid && measChan == 3'd7 && !cfgWrEn) |=> $stable(alarm));

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_chk
      // R6 and R9: no own strobe, no config write -> bit holds
      a_r6_bit_holds: assert property (@(posedge clk) disable iff (!rstN)
        (!(measValid && measChan == 3'(gc)) && !cfgWrEn) |=> $stable(alarm[gc]));
      // R5: a set disable bit silences the line next cycle
      a_r5_disable_masks: assert property (@(posedge clk) disable iff (!rstN)
        (cfgWrEn && cfgWrData[gc]) |=> !alarm[gc]);
    end
  endgenerate
endmodule

bind sensor_alarm sensor_alarm_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .measValid (measValid),
  .measChan  (measChan),
  .alarm     (alarm)
);

// File: tb/sensor_alarm_test.sv
`timescale 1ns/1ps
module sensor_alarm_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        thrWrEn = 1'b0;
  logic [3:0]  thrWrAddr = '0;
  logic [15:0] thrWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgWrData = '0;
  logic        measValid = 1'b0;
  logic [2:0]  measChan = '0;
  logic [11:0] measCode = '0;
  logic [6:0]  alarm;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R7";

  int thrM [16];
  int stM  [7];
  int disM = 0;

  always #2.5 clk = ~clk;

  sensor_alarm uut (
    .clk(clk), .rstN(rstN), .thrWrEn(thrWrEn), .thrWrAddr(thrWrAddr),
    .thrWrData(thrWrData), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .measValid(measValid), .measChan(measChan), .measCode(measCode),
    .alarm(alarm)
  );

  function automatic int hiIdx(int ch);
    return (ch < 3) ? ch : ch + 5;
  endfunction
  function automatic int loIdx(int ch);
    return (ch < 3) ? ch + 4 : ch + 9;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) thrM[i] = ((i % 8) >= 4) ? 0 : 'hFFF0;
    for (int c = 0; c < 7; c++) stM[c] = 0;
    disM = 0;
  endtask

  initial modelReset();

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      if (measValid && measChan < 7) begin
        int ch, hi, lo, code;
        ch = int'(measChan);
        hi = thrM[hiIdx(ch)] >> 4;
        lo = thrM[loIdx(ch)] >> 4;
        code = int'(measCode);
        if (ch == 0) begin
          if (code > hi) stM[0] = 1;
          else if (code < lo) stM[0] = 0;
        end else begin
          stM[ch] = (code > hi || code < lo) ? 1 : 0;
        end
      end
      if (thrWrEn) thrM[thrWrAddr] = int'(thrWrData);
      if (cfgWrEn) disM = int'(cfgWrData);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [6:0] exp;
      for (int c = 0; c < 7; c++) exp[c] = (stM[c] != 0) && !disM[c];
      checks++;
      if (alarm !== exp) begin
        fails++;
        $display("FAIL %s: alarm=%b expected=%b at %0t", curReq, alarm, exp, $time);
      end
    end
  end

  task automatic step(bit tw, int ta, int td, bit cw, int cd, bit mv, int ch, int code);
    thrWrEn = tw; thrWrAddr = 4'(ta); thrWrData = 16'(td);
    cfgWrEn = cw; cfgWrData = 7'(cd);
    measValid = mv; measChan = 3'(ch); measCode = 12'(code);
    @(negedge clk);
    thrWrEn = 0; cfgWrEn = 0; measValid = 0;
  endtask

  task automatic wrThr(int a, int d); step(1, a, d, 0, 0, 0, 0, 0); endtask
  task automatic meas(int ch, int code); step(0, 0, 0, 0, 0, 1, ch, code); endtask
  task automatic wrCfg(int d); step(0, 0, 0, 1, d, 0, 0, 0); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    curReq = "R7";
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R7: default limits keep everything quiet
    meas(1, 'hFFF); meas(2, 0); meas(0, 'hFFF);

    // R1 / R2 on channel 1 (slots 1 and 5)
    curReq = "R1"; wrThr(1, 'h8000); wrThr(5, 'h4000);
    meas(1, 'h801);
    curReq = "R2"; meas(1, 'h800);
    curReq = "R1"; meas(1, 'h3FF);
    curReq = "R2"; meas(1, 'h400);
    // R4: channel 3 -> slots 8/12, channel 6 -> slots 11/15, low nibble ignored
    curReq = "R4"; wrThr(8, 'h600F); wrThr(12, 'h200F);
    meas(3, 'h600); meas(3, 'h601); meas(3, 'h200); meas(3, 'h1FF);
    wrThr(11, 'h7000); wrThr(15, 'h1000); meas(6, 'h7001); meas(6, 'h0FFF & 'h500);
    wrThr(3, 'h0000); wrThr(7, 'hFFF0); meas(2, 'h100);
    // R3 hysteresis on temperature (slots 0/4)
    curReq = "R3"; wrThr(0, 'hA000); wrThr(4, 'h9000);
    meas(0, 'hA01); meas(0, 'h950); meas(0, 'h900); meas(0, 'hA00);
    meas(0, 'h8FF); meas(0, 'h950); meas(0, 'hA00);
    // R6: one channel's strobe leaves the others alone
    curReq = "R6"; meas(1, 'hFFF); meas(2, 'h123); meas(4, 'h0);
    // R5 mask
    curReq = "R5"; wrCfg('h02); meas(1, 'h000); meas(1, 'h500); meas(1, 'hFFF);
    wrCfg('h00); wrCfg('h7F); wrCfg('h00);
    // R8: index 7
    curReq = "R8"; meas(7, 'hFFF); meas(7, 'h000);
    // R9: limit write does not re-evaluate; same-cycle uses old limit
    curReq = "R9"; wrThr(1, 'hFFF0); wrThr(5, 'h0000);
    meas(1, 'h100); wrThr(1, 'h0000);
    step(1, 1, 'hFFF0, 0, 0, 1, 1, 'h100);
    meas(1, 'h100);
    // mixed random traffic across all requirements
    curReq = "R1";
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 8);
      curReq = (op == 0) ? "R4" : (op == 1) ? "R5" : (op == 2) ? "R9" : "R3";
      step(op == 0 || op == 2, int'($urandom % 16), int'($urandom % 65536),
           op == 1 && ($urandom % 4 == 0), int'($urandom % 128),
           op != 0 && op != 1, int'($urandom % 8), int'($urandom % 4096));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule